// File: doc/BRIEF.md
# Receive FIFO Character Timeout Timer

This block watches a serial receiver's FIFO. It raises a flag when characters have been waiting there for too long without enough of them arriving to reach the interrupt trigger level. It counts receive-sample ticks, which come at sixteen times the baud rate. When four whole character times pass with no new character and no CPU read of the FIFO, and the FIFO still holds data, it sets a timeout flag. The interrupt unit then reports that flag.

The length of one character time follows the programmed frame: one start bit, five to eight data bits, an optional parity bit and one or two stop bits. The window therefore scales with both baud rate and frame format. Receiving a character restarts the timer, and so does a CPU read. Once the flag is set, only a CPU read, an empty FIFO or a disabled FIFO clears it.

Top module: `rx_char_timeout`

## Requirements
- R1: After synchronous reset, `timeout_flag` is 0.
- R2: With the FIFO enabled and non-empty, `timeout_flag` rises on the edge that accepts the T-th `sample_tick` since the last restart, where T = 64 × F and F = 1 + (5 + `data_len`) + `parity_on` + (`two_stop` ? 2 : 1). `data_len` encodes 0→5, 1→6, 2→7 and 3→8 data bits, so F spans 7 to 12 and T spans 448 to 768.
- R3: Only cycles with `sample_tick` high advance the timer. Idle cycles between ticks do not change the count.
- R4: While no timeout is pending, a `char_rcvd` pulse restarts the timer from zero.
- R5: A `cpu_read` pulse restarts the timer. If a timeout is pending, the pulse clears `timeout_flag` on the next edge.
- R6: Once set, `timeout_flag` stays high through further ticks and through `char_rcvd` pulses until a read, an empty FIFO or a disabled FIFO clears it.
- R7: While `fifo_nonempty` is 0 or `fifo_en` is 0, the timer is held at zero and `timeout_flag` is cleared on the next edge.
- R8: A restart (`char_rcvd` or `cpu_read`) in the same cycle as the final tick wins. No flag is raised, and a full T ticks are needed again.
- R9: Setting `two_stop` lengthens the timeout by exactly 64 ticks compared with the same frame using one stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | FIFO mode enabled |
| sample_tick | input | 1 | One-cycle pulse per receive sample (16 × baud) |
| data_len | input | 2 | Data bits code: 0→5, 1→6, 2→7, 3→8 |
| parity_on | input | 1 | Parity bit present in frame |
| two_stop | input | 1 | Two stop bits instead of one |
| fifo_nonempty | input | 1 | Receive FIFO holds at least one character |
| char_rcvd | input | 1 | Pulse: a character entered the FIFO |
| cpu_read | input | 1 | Pulse: CPU read one character from the FIFO |
| timeout_flag | output | 1 | Registered character-timeout indication |

## Verification
Two functions can land in the same cycle: the terminal tick that would set the flag, and a restart from a received character or a CPU read. The bench provokes this by advancing a fresh window to T−1 ticks and then driving the last tick together with `char_rcvd` or `cpu_read`. It judges the result by requiring the flag to stay low. It then requires exactly T further ticks before the flag rises. The same collision is checked with a pending flag and a read, where the clear must take precedence over further ticks.

// File: rtl/rxto_pkg.sv
package rxto_pkg;

  typedef enum logic [1:0] {
    DLEN_5 = 2'd0,
    DLEN_6 = 2'd1,
    DLEN_7 = 2'd2,
    DLEN_8 = 2'd3
  } data_len_e;

  typedef struct packed {
    data_len_e len;
    logic      parity_on;
    logic      two_stop;
  } frame_cfg_t;

endpackage

// File: rtl/rxto_frame_len.sv
module rxto_frame_len
  import rxto_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int CHAR_WINDOW = 4,
  parameter int MIN_DATA = 5,
  parameter int CNT_W = 10
) (
  input  frame_cfg_t       cfg,
  output logic [CNT_W-1:0] thresh
);
  localparam int TICKS_PER_BIT = OVERSAMPLE * CHAR_WINDOW;
  localparam bit IS_POW2 = (TICKS_PER_BIT & (TICKS_PER_BIT - 1)) == 0;
  localparam int SHIFT = $clog2(TICKS_PER_BIT);

  logic [3:0] frame_bits;

  always_comb begin
    frame_bits = 4'(1 + MIN_DATA) + {2'b00, cfg.len}
               + {3'b000, cfg.parity_on}
               + (cfg.two_stop ? 4'd2 : 4'd1);
  end

  generate
    if (IS_POW2) begin : g_shift
      assign thresh = CNT_W'({{(CNT_W-4){1'b0}}, frame_bits} << SHIFT);
    end else begin : g_mult
      assign thresh = CNT_W'({{(CNT_W-4){1'b0}}, frame_bits} * CNT_W'(TICKS_PER_BIT));
    end
  endgenerate

endmodule

// File: rtl/rxto_tick_counter.sv
module rxto_tick_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold_zero,
  input  logic             restart,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count
);
  logic below_limit;

  assign below_limit = count < limit;

  always_ff @(posedge clk) begin
    if (rst || hold_zero || restart) begin
      count <= '0;
    end else if (tick && below_limit) begin
      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/rxto_flag.sv
module rxto_flag (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic set,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      flag <= 1'b0;
    end else if (set) begin
      flag <= 1'b1;
    end
  end

endmodule

// File: rtl/rx_char_timeout.sv
module rx_char_timeout
  import rxto_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int CHAR_WINDOW = 4,
  parameter int MIN_DATA = 5,
  parameter int MAX_FRAME = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       fifo_en,
  input  logic       sample_tick,
  input  logic [1:0] data_len,
  input  logic       parity_on,
  input  logic       two_stop,
  input  logic       fifo_nonempty,
  input  logic       char_rcvd,
  input  logic       cpu_read,
  output logic       timeout_flag
);
  localparam int MAX_TICKS = OVERSAMPLE * CHAR_WINDOW * MAX_FRAME;
  localparam int CNT_W = $clog2(MAX_TICKS + 1);

  frame_cfg_t       cfg;
  logic [CNT_W-1:0] thresh;
  logic [CNT_W-1:0] tick_count;
  logic [CNT_W:0]   next_count;
  logic             idle_hold;
  logic             restart;
  logic             final_tick;

  always_comb begin
    cfg.len       = data_len_e'(data_len);
    cfg.parity_on = parity_on;
    cfg.two_stop  = two_stop;
  end

  // A received character only restarts the window while nothing is pending.
  assign idle_hold  = !fifo_en || !fifo_nonempty;
  assign restart    = cpu_read || (char_rcvd && !timeout_flag);
  assign next_count = {1'b0, tick_count} + 1'b1;
  assign final_tick = sample_tick && (next_count >= {1'b0, thresh});

  rxto_frame_len #(
    .OVERSAMPLE (OVERSAMPLE),
    .CHAR_WINDOW(CHAR_WINDOW),
    .MIN_DATA   (MIN_DATA),
    .CNT_W      (CNT_W)
  ) u_frame_len (
    .cfg   (cfg),
    .thresh(thresh)
  );

  rxto_tick_counter #(
    .CNT_W(CNT_W)
  ) u_counter (
    .clk      (clk),
    .rst      (rst),
    .hold_zero(idle_hold),
    .restart  (restart),
    .tick     (sample_tick),
    .limit    (thresh),
    .count    (tick_count)
  );

  rxto_flag u_flag (
    .clk  (clk),
    .rst  (rst),
    .clear(idle_hold || cpu_read),
    .set  (final_tick && !restart),
    .flag (timeout_flag)
  );

endmodule

// File: rtl/rx_char_timeout_checker.sv
module rx_char_timeout_checker #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             fifo_en,
  input logic             sample_tick,
  input logic             fifo_nonempty,
  input logic             char_rcvd,
  input logic             cpu_read,
  input logic             timeout_flag,
  input logic [CNT_W-1:0] tick_count,
  input logic [CNT_W-1:0] thresh
);
  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> !timeout_flag);

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
    (tick_count <= thresh) || !$stable(thresh));

  assert_rise_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout_flag) |-> $past(sample_tick));

  assert_char_restart_R4: assert property (@(posedge clk) disable iff (rst)
    (char_rcvd && !timeout_flag) |=> !timeout_flag);

  assert_read_clear_R5: assert property (@(posedge clk) disable iff (rst)
    cpu_read |=> !timeout_flag);

  assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (timeout_flag && !cpu_read && fifo_nonempty && fifo_en) |=> timeout_flag);

  assert_empty_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (!fifo_nonempty || !fifo_en) |=> (!timeout_flag && tick_count == '0));

endmodule

bind rx_char_timeout rx_char_timeout_checker #(
  .CNT_W(CNT_W)
) u_checker (
  .clk          (clk),
  .rst          (rst),
  .fifo_en      (fifo_en),
  .sample_tick  (sample_tick),
  .fifo_nonempty(fifo_nonempty),
  .char_rcvd    (char_rcvd),
  .cpu_read     (cpu_read),
  .timeout_flag (timeout_flag),
  .tick_count   (tick_count),
  .thresh       (thresh)
);

// File: tb/rx_char_timeout_bench.sv
module rx_char_timeout_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fifo_en = 1'b0;
  logic       sample_tick = 1'b0;
  logic [1:0] data_len = 2'd0;
  logic       parity_on = 1'b0;
  logic       two_stop = 1'b0;
  logic       fifo_nonempty = 1'b0;
  logic       char_rcvd = 1'b0;
  logic       cpu_read = 1'b0;
  logic       timeout_flag;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  rx_char_timeout u_rx_char_timeout (
    .clk          (clk),
    .rst          (rst),
    .fifo_en      (fifo_en),
    .sample_tick  (sample_tick),
    .data_len     (data_len),
    .parity_on    (parity_on),
    .two_stop     (two_stop),
    .fifo_nonempty(fifo_nonempty),
    .char_rcvd    (char_rcvd),
    .cpu_read     (cpu_read),
    .timeout_flag (timeout_flag)
  );

  function automatic int ticks_for(int len, int par, int ts);
    return 64 * (1 + 5 + len + par + (ts != 0 ? 2 : 1));
  endfunction

  task automatic check(input logic act, input logic exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: timeout_flag=%0b expected %0b", req, act, exp);
    end
  endtask

  // Drive one cycle from a negedge; returns at the following negedge.
  task automatic cyc(input logic t, input logic c, input logic r);
    sample_tick = t;
    char_rcvd   = c;
    cpu_read    = r;
    @(negedge clk);
    sample_tick = 1'b0;
    char_rcvd   = 1'b0;
    cpu_read    = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    int thr;
    int thr1;
    @(negedge clk);
    @(negedge clk);
    check(timeout_flag, 1'b0, "R1 reset");
    rst = 1'b0;
    fifo_en = 1'b1;
    fifo_nonempty = 1'b1;
    @(negedge clk);

    // R2 / R6 / R5 sweep over every frame configuration
    for (int len = 0; len < 4; len++) begin
      for (int par = 0; par < 2; par++) begin
        for (int ts = 0; ts < 2; ts++) begin
          data_len = 2'(len);
          parity_on = par[0];
          two_stop = ts[0];
          thr = ticks_for(len, par, ts);
          cyc(1'b0, 1'b1, 1'b0);
          ticks(thr - 1);
          check(timeout_flag, 1'b0, "R2 before threshold");
          ticks(1);
          check(timeout_flag, 1'b1, "R2 at threshold");
          ticks(20);
          cyc(1'b0, 1'b1, 1'b0);
          check(timeout_flag, 1'b1, "R6 sticky");
          cyc(1'b0, 1'b0, 1'b1);
          check(timeout_flag, 1'b0, "R5 read clears");
        end
      end
    end

    // R9: two stop bits add 64 ticks (8 data, no parity)
    data_len = 2'd3; parity_on = 1'b0; two_stop = 1'b0;
    thr1 = ticks_for(3, 0, 0);
    two_stop = 1'b1;
    cyc(1'b0, 1'b0, 1'b1);
    ticks(thr1 + 63);
    check(timeout_flag, 1'b0, "R9 one-stop length not enough");
    ticks(1);
    check(timeout_flag, 1'b1, "R9 extra 64 ticks");
    two_stop = 1'b0;

    // R3: idle cycles between ticks
    data_len = 2'd0; parity_on = 1'b0;
    thr = ticks_for(0, 0, 0);
    cyc(1'b0, 1'b0, 1'b1);
    for (int i = 0; i < thr - 1; i++) begin
      cyc(1'b1, 1'b0, 1'b0);
      cyc(1'b0, 1'b0, 1'b0);
      cyc(1'b0, 1'b0, 1'b0);
    end
    check(timeout_flag, 1'b0, "R3 idle cycles not counted");
    cyc(1'b1, 1'b0, 1'b0);
    check(timeout_flag, 1'b1, "R3 tick count reached");

    // R4: received char restarts mid-window
    cyc(1'b0, 1'b0, 1'b1);
    ticks(thr - 10);
    cyc(1'b0, 1'b1, 1'b0);
    ticks(thr - 1);
    check(timeout_flag, 1'b0, "R4 restart by char");
    ticks(1);
    check(timeout_flag, 1'b1, "R4 full window after char");

    // R8: collision of final tick with read, then with char
    cyc(1'b0, 1'b0, 1'b1);
    ticks(thr - 1);
    cyc(1'b1, 1'b0, 1'b1);
    check(timeout_flag, 1'b0, "R8 read beats final tick");
    ticks(thr - 1);
    check(timeout_flag, 1'b0, "R8 window restarted by read");
    ticks(1);
    check(timeout_flag, 1'b1, "R8 flag after fresh window");
    cyc(1'b0, 1'b0, 1'b1);
    ticks(thr - 1);
    cyc(1'b1, 1'b1, 1'b0);
    check(timeout_flag, 1'b0, "R8 char beats final tick");
    ticks(thr - 1);
    check(timeout_flag, 1'b0, "R8 window restarted by char");
    ticks(1);
    check(timeout_flag, 1'b1, "R8 flag after char window");

    // R7: empty FIFO clears and holds; disabled FIFO likewise
    fifo_nonempty = 1'b0;
    cyc(1'b0, 1'b0, 1'b0);
    check(timeout_flag, 1'b0, "R7 empty clears flag");
    ticks(thr + 20);
    check(timeout_flag, 1'b0, "R7 empty holds timer");
    fifo_nonempty = 1'b1;
    ticks(thr - 1);
    check(timeout_flag, 1'b0, "R7 count restarts from zero");
    ticks(1);
    check(timeout_flag, 1'b1, "R7 flag after refill window");
    fifo_en = 1'b0;
    cyc(1'b0, 1'b0, 1'b0);
    check(timeout_flag, 1'b0, "R7 disable clears flag");
    ticks(thr + 5);
    check(timeout_flag, 1'b0, "R7 disabled holds timer");
    fifo_en = 1'b1;
    ticks(thr);
    check(timeout_flag, 1'b1, "R7 re-enabled window");

    // R1: reset mid-flag
    rst = 1'b1;
    cyc(1'b0, 1'b0, 1'b0);
    check(timeout_flag, 1'b0, "R1 reset clears flag");
    rst = 1'b0;
    @(negedge clk);
    finish_run();
  end

endmodule